// File: doc/BRIEF.md
# Carry-Select Arithmetic Logic Unit

This block is a purely combinational arithmetic and logic unit for a datapath. It accepts two operand words, a carry input and a three-bit operation code. In the same cycle it returns a result word, a carry out, a zero flag and a signed overflow flag. Addition and subtraction share one adder. For subtraction, a 2:1 mux feeds the bitwise complement of the second operand, and the carry into bit 0 is forced high.

The adder is split at a parameterised boundary. The lower segment ripples on its own. Two copies of the upper segment run in parallel, one assuming a carry of 0 and one a carry of 1. The lower segment's carry out then picks one upper sum and the final carry. A parameter can replace this with a single ripple chain for area-bound builds.

The zero flag is a wide NOR over the result. Overflow is the carry entering the most significant bit XOR the carry leaving it. Two operands are tested for equality by subtracting them and reading the zero flag.

Top module: `cs_alu`

## Requirements
- R1: With mode 000 (add), {carry_o, result_o} equals op_a_i + op_b_i + carry_i as an unsigned sum one bit wider than the operands.
- R2: With mode 001 (subtract), result_o equals op_a_i + ~op_b_i + 1 and carry_i has no effect. carry_o is 1 exactly when op_a_i >= op_b_i as unsigned values.
- R3: Mode 010 gives the bitwise AND of the operands, mode 011 the bitwise OR and mode 100 the bitwise XOR.
- R4: In every mode, zero_o is 1 exactly when all bits of result_o are 0.
- R5: In add and subtract, ovf_o is 1 exactly when the signed result is out of range. That is the case when the sign bit of the value actually added differs from the result's sign while both addends share a sign.
- R6: In modes 010, 011 and 100, carry_o and ovf_o are 0.
- R7: Codes 101, 110 and 111 give result_o = 0, carry_o = 0, ovf_o = 0 and zero_o = 1.
- R8: A carry produced by the lower segment reaches the upper segment, for example 0x0000FFFF + 1 = 0x00010000 and 0xFFFFFFFF + 0 + carry 1 = 0 with carry_o = 1.
- R9: Subtracting equal operands gives result_o = 0, zero_o = 1, carry_o = 1 and ovf_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| carry_i | input | 1 | Carry into bit 0 for add |
| mode_i | input | 3 | Operation code |
| result_o | output | 32 | Result word |
| carry_o | output | 1 | Carry out of the top bit (arithmetic only) |
| zero_o | output | 1 | All result bits clear |
| ovf_o | output | 1 | Signed overflow (arithmetic only) |

## Verification
Within one evaluation, the carry-select choice and the overflow flag meet: a carry that crosses the segment boundary can also decide whether the sign bit overflows. The bench provokes this with directed operands: 0x7FFFFFFF + 1, 0x80000000 - 1, 0x0000FFFF + 1 and all-ones words with carry in. It also uses seeded random words whose halves are often forced to all ones. Every result, carry, zero and overflow value is judged against a bench function built on wide integer arithmetic and the sign rule.

// File: rtl/cs_alu_pkg.sv
package cs_alu_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_OR  = 3'd3,
      OP_XOR = 3'd4
   } alu_op_e;

   typedef enum logic [1:0] {
      LOG_AND  = 2'd0,
      LOG_OR   = 2'd1,
      LOG_XOR  = 2'd2,
      LOG_NONE = 2'd3
   } log_sel_e;
endpackage

// File: rtl/cs_ripple_seg.sv
module cs_ripple_seg #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         c_i,
   output logic [W-1:0] s_o,
   output logic         c_o
);
   logic [W:0] chain;

   assign chain[0] = c_i;

   for (genvar k = 0; k < W; k++) begin : g_bit
      assign s_o[k]       = a_i[k] ^ b_i[k] ^ chain[k];
      assign chain[k + 1] = (a_i[k] & b_i[k]) | (a_i[k] & chain[k]) | (b_i[k] & chain[k]);
   end

   assign c_o = chain[W];
endmodule

// File: rtl/cs_adder.sv
module cs_adder #(
   parameter int WIDTH     = 32,
   parameter int LOW_W     = 16,
   parameter bit SELECT_EN = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             c_i,
   output logic [WIDTH-1:0] s_o,
   output logic             c_o,
   output logic             c_msb_o
);
   localparam int HI_W = WIDTH - LOW_W;

   if (WIDTH < 2) begin : g_bad_width
      $error("cs_adder: WIDTH must be at least 2");
   end
   if (LOW_W < 1 || LOW_W >= WIDTH) begin : g_bad_split
      $error("cs_adder: LOW_W must lie in 1..WIDTH-1");
   end

   if (SELECT_EN) begin : g_select
      logic [LOW_W-1:0] s_lo;
      logic             c_lo;
      logic [HI_W-1:0]  s_hi0, s_hi1;
      logic             c_hi0, c_hi1;

      cs_ripple_seg #(.W(LOW_W)) u_lo (
         .a_i(a_i[LOW_W-1:0]), .b_i(b_i[LOW_W-1:0]), .c_i(c_i),
         .s_o(s_lo), .c_o(c_lo));

      cs_ripple_seg #(.W(HI_W)) u_hi0 (
         .a_i(a_i[WIDTH-1:LOW_W]), .b_i(b_i[WIDTH-1:LOW_W]), .c_i(1'b0),
         .s_o(s_hi0), .c_o(c_hi0));

      cs_ripple_seg #(.W(HI_W)) u_hi1 (
         .a_i(a_i[WIDTH-1:LOW_W]), .b_i(b_i[WIDTH-1:LOW_W]), .c_i(1'b1),
         .s_o(s_hi1), .c_o(c_hi1));

      always_comb begin
         if (c_lo) begin
            s_o = {s_hi1, s_lo};
            c_o = c_hi1;
         end else begin
            s_o = {s_hi0, s_lo};
            c_o = c_hi0;
         end
      end
   end else begin : g_ripple
      cs_ripple_seg #(.W(WIDTH)) u_full (
         .a_i(a_i), .b_i(b_i), .c_i(c_i), .s_o(s_o), .c_o(c_o));
   end

   // carry entering the top bit recovered from its sum bit
   assign c_msb_o = s_o[WIDTH-1] ^ a_i[WIDTH-1] ^ b_i[WIDTH-1];
endmodule

// File: rtl/cs_bitwise.sv
module cs_bitwise
   import cs_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  log_sel_e         sel_i,
   output logic [WIDTH-1:0] y_o
);
   always_comb begin
      unique case (sel_i)
         LOG_AND: y_o = a_i & b_i;
         LOG_OR:  y_o = a_i | b_i;
         LOG_XOR: y_o = a_i ^ b_i;
         default: y_o = '0;
      endcase
   end
endmodule

// File: rtl/cs_flag_gen.sv
module cs_flag_gen #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] res_i,
   input  logic             arith_i,
   input  logic             c_out_i,
   input  logic             c_msb_i,
   output logic             zero_o,
   output logic             carry_o,
   output logic             ovf_o
);
   assign zero_o  = ~|res_i;
   assign carry_o = arith_i & c_out_i;
   assign ovf_o   = arith_i & (c_out_i ^ c_msb_i);
endmodule

// File: rtl/cs_alu.sv
module cs_alu
   import cs_alu_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter bit SELECT_EN = 1'b1
) (
   input  logic [WIDTH-1:0] op_a_i,
   input  logic [WIDTH-1:0] op_b_i,
   input  logic             carry_i,
   input  logic [2:0]       mode_i,
   output logic [WIDTH-1:0] result_o,
   output logic             carry_o,
   output logic             zero_o,
   output logic             ovf_o
);
   localparam int LOW_W = WIDTH / 2;

   logic             is_add, is_sub, is_arith;
   log_sel_e         log_sel;
   logic [WIDTH-1:0] b_eff;
   logic             cin_eff;
   logic [WIDTH-1:0] sum;
   logic             sum_c, sum_cmsb;
   logic [WIDTH-1:0] log_y;

   always_comb begin
      is_add  = 1'b0;
      is_sub  = 1'b0;
      log_sel = LOG_NONE;
      case (mode_i)
         OP_ADD:  is_add  = 1'b1;
         OP_SUB:  is_sub  = 1'b1;
         OP_AND:  log_sel = LOG_AND;
         OP_OR:   log_sel = LOG_OR;
         OP_XOR:  log_sel = LOG_XOR;
         default: log_sel = LOG_NONE;
      endcase
   end

   assign is_arith = is_add | is_sub;
   assign b_eff    = is_sub ? ~op_b_i : op_b_i;
   assign cin_eff  = is_sub | (is_add & carry_i);

   cs_adder #(.WIDTH(WIDTH), .LOW_W(LOW_W), .SELECT_EN(SELECT_EN)) u_adder (
      .a_i(op_a_i), .b_i(b_eff), .c_i(cin_eff),
      .s_o(sum), .c_o(sum_c), .c_msb_o(sum_cmsb));

   cs_bitwise #(.WIDTH(WIDTH)) u_logic (
      .a_i(op_a_i), .b_i(op_b_i), .sel_i(log_sel), .y_o(log_y));

   assign result_o = is_arith ? sum : log_y;

   cs_flag_gen #(.WIDTH(WIDTH)) u_flags (
      .res_i(result_o), .arith_i(is_arith), .c_out_i(sum_c), .c_msb_i(sum_cmsb),
      .zero_o(zero_o), .carry_o(carry_o), .ovf_o(ovf_o));
endmodule

// File: rtl/cs_alu_chk.sv
module cs_alu_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] op_a_i,
   input logic [WIDTH-1:0] op_b_i,
   input logic             carry_i,
   input logic [2:0]       mode_i,
   input logic [WIDTH-1:0] result_o,
   input logic             carry_o,
   input logic             zero_o,
   input logic             ovf_o
);
   logic [WIDTH:0] wide_add;
   logic [WIDTH:0] wide_sub;

   always_comb begin
      wide_add = {1'b0, op_a_i} + {1'b0, op_b_i} + {{WIDTH{1'b0}}, carry_i};
      wide_sub = {1'b0, op_a_i} + {1'b0, ~op_b_i} + {{WIDTH{1'b0}}, 1'b1};
      if (mode_i == 3'd0) begin
         AST_ADD_SUM: assert ({carry_o, result_o} == wide_add) else $error("add sum"); // R1
         AST_ADD_OVF: assert (ovf_o == ((op_a_i[WIDTH-1] == op_b_i[WIDTH-1]) &&
                              (result_o[WIDTH-1] != op_a_i[WIDTH-1]))) else $error("add ovf"); // R5
      end
      if (mode_i == 3'd1) begin
         AST_SUB_DIFF: assert ({carry_o, result_o} == wide_sub) else $error("sub diff"); // R2
         AST_SUB_EQ: assert ((op_a_i != op_b_i) || (zero_o && carry_o && !ovf_o)) else $error("sub eq"); // R9
      end
      AST_ZERO_FLAG: assert (zero_o == (result_o == '0)) else $error("zero flag"); // R4
      if (mode_i == 3'd2 || mode_i == 3'd3 || mode_i == 3'd4) begin
         AST_LOGIC_FLAGS: assert (!carry_o && !ovf_o) else $error("logic flags"); // R6
      end
      if (mode_i > 3'd4) begin
         AST_UNUSED_CODE: assert (result_o == '0 && !carry_o && !ovf_o && zero_o) else $error("unused code"); // R7
      end
   end
endmodule

bind cs_alu cs_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .op_a_i(op_a_i), .op_b_i(op_b_i), .carry_i(carry_i), .mode_i(mode_i),
   .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o), .ovf_o(ovf_o));

// File: tb/sim_cs_alu.sv
module sim_cs_alu;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;
   localparam int WATCHDOG = 100000;

   logic         clk = 1'b0;
   logic [W-1:0] a, b;
   logic         cin;
   logic [2:0]   mode;
   logic [W-1:0] res;
   logic         cout, zf, of;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cs_alu u0 (
      .op_a_i(a), .op_b_i(b), .carry_i(cin), .mode_i(mode),
      .result_o(res), .carry_o(cout), .zero_o(zf), .ovf_o(of));

   typedef struct packed {
      logic [W-1:0] r;
      logic         c;
      logic         z;
      logic         v;
   } exp_t;

   function automatic exp_t ref_model(logic [W-1:0] x, logic [W-1:0] y, logic ci, logic [2:0] m);
      exp_t e;
      logic [W:0] t;
      e = '0;
      case (m)
         3'd0: begin
            t = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
            e.r = t[W-1:0];
            e.c = t[W];
            e.v = (x[W-1] == y[W-1]) && (e.r[W-1] != x[W-1]);
         end
         3'd1: begin
            e.r = x - y;
            e.c = (x >= y);
            e.v = (x[W-1] != y[W-1]) && (e.r[W-1] != x[W-1]);
         end
         3'd2: e.r = x & y;
         3'd3: e.r = x | y;
         3'd4: e.r = x ^ y;
         default: e.r = '0;
      endcase
      e.z = (e.r == '0);
      return e;
   endfunction

   task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s a=%h b=%h cin=%0d mode=%0d actual=%h expected=%h",
                  tag, a, b, cin, mode, act, expv);
      end
   endtask

   task automatic run(logic [W-1:0] x, logic [W-1:0] y, logic ci, logic [2:0] m, string extra);
      exp_t e;
      string rt, ct, vt;
      @(posedge clk);
      a = x; b = y; cin = ci; mode = m;
      @(negedge clk);
      e = ref_model(x, y, ci, m);
      case (m)
         3'd0: begin rt = "R1"; ct = "R1"; vt = "R5"; end
         3'd1: begin rt = "R2"; ct = "R2"; vt = "R5"; end
         3'd2, 3'd3, 3'd4: begin rt = "R3"; ct = "R6"; vt = "R6"; end
         default: begin rt = "R7"; ct = "R7"; vt = "R7"; end
      endcase
      check({rt, extra, " result"}, res, e.r);
      check({ct, extra, " carry"}, {{(W-1){1'b0}}, cout}, {{(W-1){1'b0}}, e.c});
      check({"R4", extra, " zero"}, {{(W-1){1'b0}}, zf}, {{(W-1){1'b0}}, e.z});
      check({vt, extra, " ovf"}, {{(W-1){1'b0}}, of}, {{(W-1){1'b0}}, e.v});
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] ra, rb;
      a = '0; b = '0; cin = 1'b0; mode = 3'd0;
      void'($urandom(32'd1234));

      // idle inputs: zero sum, zero flag set
      run(32'h0, 32'h0, 1'b0, 3'd0, " idle");
      // R5 overflow corners
      run(32'h7FFFFFFF, 32'h1, 1'b0, 3'd0, " maxpos+1");
      run(32'h80000000, 32'h1, 1'b0, 3'd1, " minneg-1");
      run(32'h7FFFFFFF, 32'h0, 1'b1, 3'd0, " maxpos+cin");
      // R8 carry across the segment boundary
      run(32'h0000FFFF, 32'h1, 1'b0, 3'd0, " R8 boundary");
      run(32'hFFFFFFFF, 32'h0, 1'b1, 3'd0, " R8 wrap");
      run(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 3'd0, " R8 allones");
      // R9 equality through subtract
      run(32'h12345678, 32'h12345678, 1'b0, 3'd1, " R9 equal");
      run(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 3'd1, " R9 equal cin");
      // R2 carry_i ignored in subtract
      run(32'h00000005, 32'h00000009, 1'b0, 3'd1, " R2 cin0");
      run(32'h00000005, 32'h00000009, 1'b1, 3'd1, " R2 cin1");
      // R3 / R6 logic on all-ones
      run(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 3'd2, " R3 and");
      run(32'hFFFFFFFF, 32'h0F0F0F0F, 1'b1, 3'd3, " R3 or");
      run(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 3'd4, " R3 xor");
      // R7 unused codes
      for (int m = 5; m < 8; m++) run(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 3'(m), " R7 unused");

      for (int i = 0; i < 3000; i++) begin
         ra = $urandom;
         rb = $urandom;
         if ($urandom % 4 == 0) ra[15:0] = 16'hFFFF;
         if ($urandom % 4 == 0) rb = ra;
         if ($urandom % 8 == 0) ra[31] = ~ra[31];
         run(ra, rb, 1'($urandom % 2), 3'($urandom % 8), " random");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule